// File: doc/BRIEF.md
# Bounded Downward Stack Controller

This block manages a last-in, first-out stack held in an external single-port word memory. It keeps a stack pointer that always addresses the most recently stored word. The stack grows toward lower addresses: a store first moves the pointer down by one and then writes the word there. A retrieve first reads the word at the pointer and then moves the pointer up by one. The memory bus has a one-cycle read latency.

The highest storage slot and the lowest permitted slot are parameters. The pointer value one above the highest slot means the stack is empty. A pointer equal to the lowest slot means it is full. The block never stalls a request it cannot serve. It finishes the request with a one-cycle completion pulse and a result bit that reads 0 for success and 1 for refusal. A refused request leaves the pointer, the memory and the read-data output untouched. With the default parameters the slots run from 16'h3FFF down to 16'h3FFB, which gives five entries, and the empty pointer value is 16'h4000.

Top module: `lifo_down_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `sp` equals 16'h4000 (highest slot + 1) and `done`, `err`, `mem_we` and `mem_re` are 0.
- R2: A push requested alone when `sp` is not the lowest slot completes in the cycle after the sampling edge. In that cycle `done`=1, `err`=0, `sp` is one lower, and `mem_we`=1 with `mem_addr` equal to the new `sp` and `mem_wdata` equal to the pushed word.
- R3: A pop requested alone when `sp` is not the empty value drives `mem_re`=1 with `mem_addr`=`sp` in the cycle after the sampling edge. `done`=1 and `err`=0 follow in the third cycle after that edge, and in that same cycle `rd_data` holds the word read and `sp` is one higher.
- R4: Pops return the pushed words in reverse order of pushing.
- R5: A pop while `sp` equals the empty value 16'h4000 completes in the cycle after the sampling edge with `done`=1 and `err`=1. It leaves `sp` and `rd_data` unchanged and makes no memory access.
- R6: A push while `sp` equals the lowest slot 16'h3FFB completes in the cycle after the sampling edge with `done`=1 and `err`=1. It leaves `sp` unchanged and makes no memory write.
- R7: Push and pop requested in the same cycle complete in the cycle after the sampling edge with `done`=1 and `err`=1, and nothing changes.
- R8: `done` is high for exactly one cycle per accepted request. `err` keeps the last result until the next completion.
- R9: Requests that arrive while a pop is waiting for its read data are ignored. They produce no completion and no change to `sp`.
- R10: `sp` stays within [lowest slot, highest slot + 1] and changes only in a cycle with `done`=1 and `err`=0. `mem_we` and `mem_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Request to store `wr_data` |
| pop_req | input | 1 | Request to retrieve the top word |
| wr_data | input | 16 | Word to push |
| rd_data | output | 16 | Last word popped |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Result of the last request: 0 success, 1 refused |
| sp | output | 16 | Current stack pointer |
| mem_addr | output | 16 | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_re | output | 1 | Memory read enable; data returns one cycle later |
| mem_rdata | input | 16 | Memory read data |

## Verification
The hardest situation to reach from the ports is a request that arrives while a pop is waiting for memory. The stimulus builds it by raising `push_req` in the cycle right after a pop has been accepted, and then checks that no extra completion appears and that the pointer moves only once. The two boundary refusals, a push at the full pointer and a pop at the empty pointer, come from directed fill and drain sequences. They also come from a random stream that mixes pushes, pops, simultaneous requests and these interfering pops, all driven by a fixed-seed `$urandom`. The stack is only five entries deep, so that stream hits both limits many times.

// File: rtl/lifo_pkg.sv
package lifo_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_WAIT = 2'd1,
    ST_RD_TAKE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/lifo_ptr.sv
module lifo_ptr #(
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE  = 16'h3FFF,
  parameter logic [AW-1:0] LIMIT = 16'h3FFB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec,
  input  logic          inc,
  output logic [AW-1:0] sp,
  output logic          is_empty,
  output logic          is_full
);
  localparam logic [AW-1:0] EMPTY_PTR = BASE + 1'b1;

  logic [AW-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (rst)      sp_q <= EMPTY_PTR;
    else if (dec) sp_q <= sp_q - 1'b1;
    else if (inc) sp_q <= sp_q + 1'b1;
  end

  assign sp       = sp_q;
  assign is_empty = (sp_q == EMPTY_PTR);
  assign is_full  = (sp_q == LIMIT);
endmodule

// File: rtl/lifo_seq.sv
module lifo_seq
  import lifo_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] mem_rdata,
  input  logic [AW-1:0] sp,
  input  logic          is_empty,
  input  logic          is_full,
  output logic          sp_dec,
  output logic          sp_inc,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          err
);
  seq_state_t state;
  logic idle, go_push, go_pop, refuse;

  assign idle    = (state == ST_IDLE);
  assign go_push = idle && push_req && !pop_req && !is_full;
  assign go_pop  = idle && pop_req && !push_req && !is_empty;
  assign refuse  = idle && (push_req || pop_req) && !go_push && !go_pop;
  assign sp_dec  = go_push;
  assign sp_inc  = (state == ST_RD_TAKE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_wdata <= '0;
      rd_data   <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      done   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (go_push) begin
            mem_we    <= 1'b1;
            mem_addr  <= sp - 1'b1;
            mem_wdata <= wr_data;
            done      <= 1'b1;
            err       <= 1'b0;
          end else if (go_pop) begin
            mem_re   <= 1'b1;
            mem_addr <= sp;
            state    <= ST_RD_WAIT;
          end else if (refuse) begin
            done <= 1'b1;
            err  <= 1'b1;
          end
        end
        ST_RD_WAIT: state <= ST_RD_TAKE;
        ST_RD_TAKE: begin
          rd_data <= mem_rdata;
          done    <= 1'b1;
          err     <= 1'b0;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lifo_down_ctrl.sv
module lifo_down_ctrl #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE  = 16'h3FFF,
  parameter logic [AW-1:0] LIMIT = 16'h3FFB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata
);
  logic sp_dec, sp_inc, is_empty, is_full;

  lifo_ptr #(.AW(AW), .BASE(BASE), .LIMIT(LIMIT)) u_ptr (
    .clk(clk), .rst(rst), .dec(sp_dec), .inc(sp_inc),
    .sp(sp), .is_empty(is_empty), .is_full(is_full)
  );

  lifo_seq #(.DW(DW), .AW(AW)) u_seq (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
    .wr_data(wr_data), .mem_rdata(mem_rdata), .sp(sp),
    .is_empty(is_empty), .is_full(is_full),
    .sp_dec(sp_dec), .sp_inc(sp_inc),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .rd_data(rd_data), .done(done), .err(err)
  );
endmodule

// File: rtl/lifo_down_chk.sv
module lifo_down_chk #(
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE  = 16'h3FFF,
  parameter logic [AW-1:0] LIMIT = 16'h3FFB
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] sp,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          mem_re,
  input logic          done,
  input logic          err
);
  localparam logic [AW-1:0] EMPTY_PTR = BASE + 1'b1;

  a_r1_reset_empty: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sp == EMPTY_PTR && !done && !err && !mem_we && !mem_re));

  a_r10_sp_in_range: assert property (@(posedge clk) disable iff (rst)
    (sp >= LIMIT && sp <= EMPTY_PTR));

  a_r2_push_write: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr == sp && $past(sp) == sp + 1'b1 && done && !err));

  a_r3_pop_step: assert property (@(posedge clk) disable iff (rst)
    (done && !err && !mem_we) |-> (sp == $past(sp) + 1'b1));

  // R5, R6, R7: a refusal leaves pointer and memory alone
  a_r7_refusal_inert: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> ($stable(sp) && !mem_we && !mem_re));

  a_r10_sp_moves_on_success: assert property (@(posedge clk) disable iff (rst)
    !$stable(sp) |-> (done && !err));

  a_r10_one_access: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));
endmodule

bind lifo_down_ctrl lifo_down_chk #(.AW(AW), .BASE(BASE), .LIMIT(LIMIT)) u_chk (
  .clk(clk), .rst(rst), .sp(sp), .mem_addr(mem_addr), .mem_we(mem_we),
  .mem_re(mem_re), .done(done), .err(err)
);

// File: tb/tb_lifo_down_ctrl.sv
module tb_lifo_down_ctrl;
  localparam logic [15:0] LIMIT = 16'h3FFB;
  localparam logic [15:0] EMPTY = 16'h4000;
  localparam int DEPTH = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push_req = 1'b0, pop_req = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data, sp, mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic done, err, mem_we, mem_re;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  logic [15:0] bram [0:DEPTH-1];
  logic [15:0] mdl_stk [0:DEPTH-1];
  int mdl_cnt = 0;
  logic [15:0] mdl_rd = '0;

  always #5 clk = ~clk;

  lifo_down_ctrl dut (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
    .wr_data(wr_data), .rd_data(rd_data), .done(done), .err(err), .sp(sp),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  // external memory with one-cycle read latency
  always @(posedge clk) begin
    if (mem_we) begin
      if (int'(mem_addr - LIMIT) < DEPTH) bram[int'(mem_addr - LIMIT)] <= mem_wdata;
    end
    if (mem_re) begin
      if (int'(mem_addr - LIMIT) < DEPTH) mem_rdata <= bram[int'(mem_addr - LIMIT)];
    end
  end

  function automatic logic [15:0] exp_sp();
    return EMPTY - 16'(mdl_cnt);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input bit p, input bit q, input logic [15:0] d, input bit noise_in);
    bit ok, noise;
    int lat, exp_lat;
    string tag;
    logic [15:0] sp_before;
    if (p && q) begin ok = 1'b0; tag = "R7"; end
    else if (p) begin ok = (mdl_cnt < DEPTH); tag = ok ? "R2" : "R6"; end
    else begin ok = (mdl_cnt > 0); tag = ok ? "R3" : "R5"; end
    noise = noise_in && ok && q && !p;
    exp_lat = (q && !p && ok) ? 3 : 1;
    sp_before = sp;
    @(negedge clk);
    push_req = p; pop_req = q; wr_data = d;
    @(negedge clk);
    push_req = noise; pop_req = 1'b0;
    lat = 1;
    if (p && !q && ok) begin
      chk("R2 we", 32'(mem_we), 32'd1);
      chk("R2 addr", 32'(mem_addr), 32'(exp_sp() - 16'd1));
      chk("R2 wdata", 32'(mem_wdata), 32'(d));
    end
    if (q && !p && ok) begin
      chk("R3 re", 32'(mem_re), 32'd1);
      chk("R3 addr", 32'(mem_addr), 32'(sp_before));
    end
    if (!ok) chk({tag, " no access"}, 32'({mem_we, mem_re}), 32'd0);
    while (!done && lat < 6) begin
      @(negedge clk);
      push_req = 1'b0;
      lat++;
    end
    chk({"R8 latency ", tag}, 32'(lat), 32'(exp_lat));
    if (ok && p) begin mdl_stk[mdl_cnt] = d; mdl_cnt++; end
    if (ok && q) begin mdl_cnt--; mdl_rd = mdl_stk[mdl_cnt]; end
    chk({tag, " err"}, 32'(err), ok ? 32'd0 : 32'd1);
    chk({tag, " sp"}, 32'(sp), 32'(exp_sp()));
    if (q && !p) chk(ok ? "R4 rd_data" : "R5 rd_data", 32'(rd_data), 32'(mdl_rd));
    @(negedge clk);
    chk("R8 single done", 32'(done), 32'd0);
    chk("R8 err held", 32'(err), ok ? 32'd0 : 32'd1);
    if (noise) begin
      @(negedge clk);
      chk("R9 ignored done", 32'(done), 32'd0);
      chk("R9 ignored sp", 32'(sp), 32'(exp_sp()));
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk("R1 sp in reset", 32'(sp), 32'(EMPTY));
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sp", 32'(sp), 32'(EMPTY));
    chk("R1 done/err", 32'({done, err}), 32'd0);
    chk("R1 mem idle", 32'({mem_we, mem_re}), 32'd0);

    run_op(1'b0, 1'b1, 16'h0, 1'b0);              // R5 pop on empty
    for (int i = 0; i < DEPTH; i++) run_op(1'b1, 1'b0, 16'hA100 + 16'(i), 1'b0);
    run_op(1'b1, 1'b0, 16'hDEAD, 1'b0);           // R6 push on full
    run_op(1'b1, 1'b1, 16'hBEEF, 1'b0);           // R7 both at once
    run_op(1'b0, 1'b1, 16'h0, 1'b1);              // R9 noise during pop
    for (int i = 0; i < DEPTH; i++) run_op(1'b0, 1'b1, 16'h0, 1'b0);
    run_op(1'b0, 1'b1, 16'h0, 1'b0);              // R5 again after drain
    run_op(1'b1, 1'b1, 16'h1234, 1'b0);           // R7 on empty

    for (int n = 0; n < 400; n++) begin
      int r;
      logic [15:0] d;
      r = int'($urandom % 8);
      d = 16'($urandom);
      if (r < 3)       run_op(1'b1, 1'b0, d, 1'b0);
      else if (r < 6)  run_op(1'b0, 1'b1, d, 1'b0);
      else if (r == 6) run_op(1'b1, 1'b1, d, 1'b0);
      else             run_op(1'b0, 1'b1, d, 1'b1);
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule